// File: doc/BRIEF.md
# Three-Mode Video Memory DMA Engine

This block moves data into the memories of a video display processor without CPU involvement. It has three modes. In bus mode it reads words from the CPU bus and writes them to video, scroll or colour memory. In copy mode it moves words from one part of video memory to another. In fill mode it writes one data value over a run of video memory. Every write goes into the shared write FIFO through a push port that has a full flag, so the engine stalls whenever the FIFO is full. Video memory takes data one byte at a time, so each video word becomes two byte entries, low byte first. Scroll and colour memory take whole words.

Software first programs the mode, source, destination, length and destination increment. It then sets the trigger bit through a control write, and that write takes effect only while the DMA-enable register bit is set. Bus and copy transfers begin at once. A fill only arms. The next word written to the data port is stored normally and becomes the fill value. The engine waits until the FIFO has written that word to memory before it starts filling. If the data port is written again during the fill, that word is stored normally and replaces the fill value for the remaining words.

Top module: `vdma_engine`

## Requirements
- R1: A trigger (ctrlWr and ctrlTrig high together while idle) starts the engine only when dmaEnable is high. A trigger while dmaEnable is low leaves the engine idle and produces no FIFO push.
- R2: In bus mode (cfgMode 0) the engine reads source words at consecutive word addresses, starting at cfgSrc with srcSel low, and writes them to the memory that cfgTarget selects (0 video, 1 scroll, 2 colour). srcData is valid one cycle after srcRd.
- R3: A word for video memory is pushed as two entries at the same address: kind 1 carrying the low byte, then kind 2 carrying the high byte. The byte sits in fifoData[7:0]. A word for scroll or colour memory is pushed as one entry of kind 0 carrying the full word.
- R4: fifoPush is never high while fifoFull is high. A transfer stalled by a full FIFO resumes later without losing or repeating any entry.
- R5: In copy mode (cfgMode 1) the engine reads video memory with srcSel high, starting at cfgSrc with consecutive word addresses, and writes the words to video memory.
- R6: In fill mode (cfgMode 2) a trigger only arms the engine. The next data-port word is written to the destination without being counted. No fill word is pushed until fifoEmpty shows that this word has been committed.
- R7: After the commit, the fill writes the fill value cfgLen times to video memory.
- R8: A data-port word accepted during a fill is written at the current destination without being counted, and the fill uses its value for every word after it.
- R9: The destination advances by cfgIncr words after every word written. The length counts down once per counted word. done rises and busy falls when the length reaches zero. A length of zero ends the transfer with no push.
- R10: A trigger while busy is ignored. An accepted trigger clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaEnable | input | 1 | Enable register bit that permits the trigger |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlTrig | input | 1 | Trigger bit carried by the control write |
| cfgMode | input | 2 | 0 bus, 1 copy, 2 or 3 fill |
| cfgTarget | input | 2 | Bus-mode target: 0 video, 1 scroll, 2 colour |
| cfgSrc | input | SRC_AW | Source start word address |
| cfgDst | input | DST_AW | Destination start word address |
| cfgLen | input | LEN_W | Word count |
| cfgIncr | input | INC_W | Destination increment per word |
| dataWr | input | 1 | Data-port write strobe |
| dataIn | input | 16 | Data-port word |
| dataReady | output | 1 | Engine accepts a data-port word this cycle |
| srcRd | output | 1 | Source read request |
| srcSel | output | 1 | 0 CPU bus, 1 video memory |
| srcAddr | output | SRC_AW | Source word address |
| srcData | input | 16 | Source word, one cycle after srcRd |
| fifoPush | output | 1 | FIFO push |
| fifoTarget | output | 2 | Target memory of the entry |
| fifoAddr | output | DST_AW | Destination word address |
| fifoKind | output | 2 | 0 word, 1 low byte, 2 high byte |
| fifoData | output | 16 | Entry data |
| fifoFull | input | 1 | FIFO cannot take a push |
| fifoEmpty | input | 1 | All FIFO entries written to memory |
| busy | output | 1 | Transfer armed or running |
| done | output | 1 | Last transfer finished |

## Verification
The bench models the FIFO, with a random drain rate, and the memories behind it. It looks for the corner cases a faulty engine would get wrong. It keeps the FIFO full long enough that an engine pushing into a full FIFO, or losing the word held during a stall, would leave wrong or missing memory contents. It checks byte order and address pairing for each video word, so swapped lanes show up as byte-swapped data. For fill, it checks that the first fill push sees an empty FIFO, so an engine that starts filling before the commit is caught. A data-port write lands partway through the fill, and an engine that counts that word, skips its address or keeps the old value leaves a wrong word sequence. It also checks that a zero length, a trigger without enable and a trigger while busy cause no pushes and leave the configuration unchanged.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam logic [1:0] MODE_BUS  = 2'd0;
  localparam logic [1:0] MODE_COPY = 2'd1;

  localparam logic [1:0] TGT_VIDEO = 2'd0;

  localparam logic [1:0] KIND_WORD = 2'd0;
  localparam logic [1:0] KIND_LO   = 2'd1;
  localparam logic [1:0] KIND_HI   = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic capSrc;
    logic capCpu;
    logic capFill;
    logic push;
    logic pushHi;
    logic wordEnd;
    logic lenDec;
  } vdmaStrobe_t;
endpackage

// File: rtl/vdma_datapath.sv
module vdma_datapath
  import vdma_pkg::*;
#(
  parameter int SRC_AW = 16,
  parameter int DST_AW = 16,
  parameter int LEN_W  = 16,
  parameter int INC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  vdmaStrobe_t       st,
  input  logic [1:0]        cfgMode,
  input  logic [1:0]        cfgTarget,
  input  logic [SRC_AW-1:0] cfgSrc,
  input  logic [DST_AW-1:0] cfgDst,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [INC_W-1:0]  cfgIncr,
  input  logic [15:0]       dataIn,
  input  logic [15:0]       srcData,
  output logic              srcSel,
  output logic [SRC_AW-1:0] srcAddr,
  output logic              fifoPush,
  output logic [1:0]        fifoTarget,
  output logic [DST_AW-1:0] fifoAddr,
  output logic [1:0]        fifoKind,
  output logic [15:0]       fifoData,
  output logic              lenZero,
  output logic              wordTgt,
  output logic              isFill
);
  logic [SRC_AW-1:0] srcA;
  logic [DST_AW-1:0] dstA;
  logic [LEN_W-1:0]  lenR;
  logic [INC_W-1:0]  incR;
  logic [15:0]       dataR;
  logic [15:0]       fillR;
  logic [1:0]        tgtR;
  logic              fillR_m;
  logic              copyR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcA    <= '0;
      dstA    <= '0;
      lenR    <= '0;
      incR    <= '0;
      dataR   <= '0;
      fillR   <= '0;
      tgtR    <= TGT_VIDEO;
      fillR_m <= 1'b0;
      copyR   <= 1'b0;
    end else begin
      if (st.loadCfg) begin
        fillR_m <= cfgMode[1];
        copyR   <= (cfgMode == MODE_COPY);
        tgtR    <= (cfgMode == MODE_BUS) ? cfgTarget : TGT_VIDEO;
        srcA    <= cfgSrc;
        dstA    <= cfgDst;
        lenR    <= cfgLen;
        incR    <= cfgIncr;
      end
      if (st.capSrc) begin
        dataR <= srcData;
        srcA  <= srcA + 1'b1;
      end
      if (st.capCpu) begin
        dataR <= dataIn;
        fillR <= dataIn;
      end
      if (st.capFill) dataR <= fillR;
      if (st.wordEnd) dstA <= dstA + DST_AW'(incR);
      if (st.lenDec)  lenR <= lenR - 1'b1;
    end
  end

  assign srcSel     = copyR;
  assign srcAddr    = srcA;
  assign isFill     = fillR_m;
  assign lenZero    = (lenR == '0);
  assign wordTgt    = (tgtR != TGT_VIDEO);
  assign fifoPush   = st.push;
  assign fifoTarget = tgtR;
  assign fifoAddr   = dstA;
  assign fifoKind   = wordTgt ? KIND_WORD : (st.pushHi ? KIND_HI : KIND_LO);
  assign fifoData   = wordTgt ? dataR : (st.pushHi ? {8'h00, dataR[15:8]} : {8'h00, dataR[7:0]});

  AST_LEN_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN) st.lenDec |-> !lenZero); // R9
  AST_HI_ONLY_VIDEO: assert property (@(posedge clk) disable iff (!rstN) (st.push && st.pushHi) |-> !wordTgt); // R3
endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
  import vdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigOk,
  input  logic        cfgFill,
  input  logic        dataWr,
  input  logic        fifoFull,
  input  logic        fifoEmpty,
  input  logic        lenZero,
  input  logic        wordTgt,
  input  logic        isFill,
  output vdmaStrobe_t st,
  output logic        srcRd,
  output logic        dataReady,
  output logic        busy,
  output logic        done
);
  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_READ, S_WAITD, S_LOWB, S_HIGHB, S_FWAIT, S_FILL
  } state_t;

  state_t state, nxt;
  logic cpuWord, fillGo, doneR;
  logic setCpu, clrCpu, startFill, finish, endWord;

  always_comb begin
    st        = '0;
    srcRd     = 1'b0;
    dataReady = 1'b0;
    nxt       = state;
    setCpu    = 1'b0;
    clrCpu    = 1'b0;
    startFill = 1'b0;
    finish    = 1'b0;
    endWord   = 1'b0;
    case (state)
      S_IDLE: if (trigOk) begin
        st.loadCfg = 1'b1;
        nxt = cfgFill ? S_ARMED : S_READ;
      end
      S_ARMED: begin
        dataReady = !fifoFull;
        if (dataWr && !fifoFull) begin
          st.capCpu = 1'b1;
          setCpu = 1'b1;
          nxt = S_LOWB;
        end
      end
      S_READ: begin
        if (lenZero) begin
          finish = 1'b1;
          nxt = S_IDLE;
        end else begin
          srcRd = 1'b1;
          nxt = S_WAITD;
        end
      end
      S_WAITD: begin
        st.capSrc = 1'b1;
        clrCpu = 1'b1;
        nxt = S_LOWB;
      end
      S_LOWB: if (!fifoFull) begin
        st.push = 1'b1;
        if (wordTgt) endWord = 1'b1;
        else nxt = S_HIGHB;
      end
      S_HIGHB: if (!fifoFull) begin
        st.push = 1'b1;
        st.pushHi = 1'b1;
        endWord = 1'b1;
      end
      S_FWAIT: if (fifoEmpty) begin
        startFill = 1'b1;
        nxt = S_FILL;
      end
      S_FILL: begin
        dataReady = !fifoFull;
        if (dataWr && !fifoFull) begin
          st.capCpu = 1'b1;
          setCpu = 1'b1;
          nxt = S_LOWB;
        end else if (lenZero) begin
          finish = 1'b1;
          nxt = S_IDLE;
        end else begin
          st.capFill = 1'b1;
          clrCpu = 1'b1;
          nxt = S_LOWB;
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (endWord) begin
      st.wordEnd = 1'b1;
      st.lenDec  = !cpuWord;
      nxt = isFill ? (fillGo ? S_FILL : S_FWAIT) : S_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cpuWord <= 1'b0;
      fillGo  <= 1'b0;
      doneR   <= 1'b0;
    end else begin
      state <= nxt;
      if (setCpu) cpuWord <= 1'b1;
      else if (clrCpu) cpuWord <= 1'b0;
      if (st.loadCfg) fillGo <= 1'b0;
      else if (startFill) fillGo <= 1'b1;
      if (st.loadCfg) doneR <= 1'b0;
      else if (finish) doneR <= 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = doneR;

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN) st.push |-> !fifoFull); // R4
  AST_FILL_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rstN) (state == S_FWAIT && !fifoEmpty) |=> (state == S_FWAIT)); // R6
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN) $rose(done) |-> lenZero); // R9
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int SRC_AW = 16,
  parameter int DST_AW = 16,
  parameter int LEN_W  = 16,
  parameter int INC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaEnable,
  input  logic              ctrlWr,
  input  logic              ctrlTrig,
  input  logic [1:0]        cfgMode,
  input  logic [1:0]        cfgTarget,
  input  logic [SRC_AW-1:0] cfgSrc,
  input  logic [DST_AW-1:0] cfgDst,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [INC_W-1:0]  cfgIncr,
  input  logic              dataWr,
  input  logic [15:0]       dataIn,
  output logic              dataReady,
  output logic              srcRd,
  output logic              srcSel,
  output logic [SRC_AW-1:0] srcAddr,
  input  logic [15:0]       srcData,
  output logic              fifoPush,
  output logic [1:0]        fifoTarget,
  output logic [DST_AW-1:0] fifoAddr,
  output logic [1:0]        fifoKind,
  output logic [15:0]       fifoData,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  output logic              busy,
  output logic              done
);
  vdmaStrobe_t st;
  logic lenZero, wordTgt, isFill;
  logic trigOk;

  assign trigOk = ctrlWr && ctrlTrig && dmaEnable;

  vdma_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trigOk    (trigOk),
    .cfgFill   (cfgMode[1]),
    .dataWr    (dataWr),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .lenZero   (lenZero),
    .wordTgt   (wordTgt),
    .isFill    (isFill),
    .st        (st),
    .srcRd     (srcRd),
    .dataReady (dataReady),
    .busy      (busy),
    .done      (done)
  );

  vdma_datapath #(
    .SRC_AW (SRC_AW),
    .DST_AW (DST_AW),
    .LEN_W  (LEN_W),
    .INC_W  (INC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .cfgMode    (cfgMode),
    .cfgTarget  (cfgTarget),
    .cfgSrc     (cfgSrc),
    .cfgDst     (cfgDst),
    .cfgLen     (cfgLen),
    .cfgIncr    (cfgIncr),
    .dataIn     (dataIn),
    .srcData    (srcData),
    .srcSel     (srcSel),
    .srcAddr    (srcAddr),
    .fifoPush   (fifoPush),
    .fifoTarget (fifoTarget),
    .fifoAddr   (fifoAddr),
    .fifoKind   (fifoKind),
    .fifoData   (fifoData),
    .lenZero    (lenZero),
    .wordTgt    (wordTgt),
    .isFill     (isFill)
  );

  AST_TRIG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN) (!busy && ctrlWr && ctrlTrig && !dmaEnable) |=> !busy); // R1
endmodule

// File: tb/vdma_engine_tb.sv
`timescale 1ns/1ps
module vdma_engine_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaEnable = 1'b0, ctrlWr = 1'b0, ctrlTrig = 1'b0;
  logic [1:0] cfgMode = '0, cfgTarget = '0;
  logic [15:0] cfgSrc = '0, cfgDst = '0, cfgLen = '0;
  logic [7:0] cfgIncr = '0;
  logic dataWr = 1'b0;
  logic [15:0] dataIn = '0;
  logic dataReady, srcRd, srcSel;
  logic [15:0] srcAddr;
  logic [15:0] srcData = '0;
  logic fifoPush;
  logic [1:0] fifoTarget, fifoKind;
  logic [15:0] fifoAddr, fifoData;
  logic fullR = 1'b0, emptyR = 1'b1;
  logic busy, done;

  always #4 clk = ~clk;

  vdma_engine u_dut (
    .clk(clk), .rstN(rstN), .dmaEnable(dmaEnable), .ctrlWr(ctrlWr), .ctrlTrig(ctrlTrig),
    .cfgMode(cfgMode), .cfgTarget(cfgTarget), .cfgSrc(cfgSrc), .cfgDst(cfgDst),
    .cfgLen(cfgLen), .cfgIncr(cfgIncr), .dataWr(dataWr), .dataIn(dataIn),
    .dataReady(dataReady), .srcRd(srcRd), .srcSel(srcSel), .srcAddr(srcAddr),
    .srcData(srcData), .fifoPush(fifoPush), .fifoTarget(fifoTarget), .fifoAddr(fifoAddr),
    .fifoKind(fifoKind), .fifoData(fifoData), .fifoFull(fullR), .fifoEmpty(emptyR),
    .busy(busy), .done(done)
  );

  typedef struct {
    logic [1:0]  tgt;
    logic [15:0] addr;
    logic [1:0]  kind;
    logic [15:0] data;
    int          qsz;
  } ent_t;

  ent_t q[$];
  ent_t logQ[$];
  logic [7:0]  vlo [int];
  logic [7:0]  vhi [int];
  logic [15:0] scr [int];
  logic [15:0] col [int];
  int drainPct = 50;
  int pushFull = 0;
  int nTests = 0, nFail = 0;
  bit finished = 0;

  function automatic logic [15:0] busWord(input logic [15:0] a);
    logic [15:0] m;
    m = a * 16'h9E37;
    return m ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] rdVid(input logic [15:0] a);
    logic [7:0] lo, hi;
    lo = vlo.exists(int'(a)) ? vlo[int'(a)] : 8'h00;
    hi = vhi.exists(int'(a)) ? vhi[int'(a)] : 8'h00;
    return {hi, lo};
  endfunction

  function automatic logic [15:0] rdMem(input logic [1:0] tgt, input logic [15:0] a);
    if (tgt == 2'd0) return rdVid(a);
    if (tgt == 2'd1) return scr.exists(int'(a)) ? scr[int'(a)] : 16'h0;
    return col.exists(int'(a)) ? col[int'(a)] : 16'h0;
  endfunction

  // FIFO and memory model: updates at the clock edge, flags via NBA
  always @(posedge clk) begin
    ent_t e;
    if (rstN && fifoPush) begin
      if (fullR) pushFull++;
      e.tgt = fifoTarget; e.addr = fifoAddr; e.kind = fifoKind; e.data = fifoData;
      e.qsz = q.size();
      q.push_back(e);
      logQ.push_back(e);
    end
    if (q.size() > 0 && int'($urandom % 100) < drainPct) begin
      e = q.pop_front();
      case (e.tgt)
        2'd0: begin
          if (e.kind == 2'd1) vlo[int'(e.addr)] = e.data[7:0];
          else if (e.kind == 2'd2) vhi[int'(e.addr)] = e.data[7:0];
        end
        2'd1: scr[int'(e.addr)] = e.data;
        default: col[int'(e.addr)] = e.data;
      endcase
    end
    fullR  <= (q.size() >= 4);
    emptyR <= (q.size() == 0);
    if (srcRd) srcData <= srcSel ? rdVid(srcAddr) : busWord(srcAddr);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic trigger(input logic [1:0] m, input logic [1:0] t, input logic [15:0] s,
                         input logic [15:0] d, input logic [15:0] l, input logic [7:0] inc);
    @(negedge clk);
    cfgMode = m; cfgTarget = t; cfgSrc = s; cfgDst = d; cfgLen = l; cfgIncr = inc;
    ctrlWr = 1'b1; ctrlTrig = 1'b1;
    @(negedge clk);
    ctrlWr = 1'b0; ctrlTrig = 1'b0;
  endtask

  task automatic cpuWrite(input logic [15:0] v);
    @(negedge clk);
    while (!dataReady) @(negedge clk);
    dataIn = v; dataWr = 1'b1;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic waitFinish();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    while (q.size() > 0 && n < 40000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    if (n >= 20000) chk(0, "R9 transfer hang", 0, 1);
  endtask

  function automatic logic [15:0] logWord(input int k);
    return {logQ[2*k+1].data[7:0], logQ[2*k].data[7:0]};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL R9 watchdog: actual hang expected finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp [16];
    logic [15:0] a;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk(!busy && !done && !fifoPush && !dataReady, "R9 reset state", {busy, done, fifoPush, dataReady}, 0);

    // R1: trigger without enable ignored
    logQ.delete();
    dmaEnable = 1'b0;
    trigger(2'd0, 2'd0, 16'h0010, 16'h0020, 16'd3, 8'd1);
    repeat (20) @(negedge clk);
    chk(!busy && logQ.size() == 0, "R1 trigger without enable", logQ.size(), 0);
    dmaEnable = 1'b1;

    // random bus and copy transfers
    for (int it = 0; it < 10; it++) begin
      int kind, len, inc, okMem, okOrd;
      logic [1:0] tgt, mode;
      logic [15:0] src, dst;
      kind = int'($urandom % 4);
      len  = 1 + int'($urandom % 8);
      inc  = 1 + int'($urandom % 3);
      drainPct = 10 + int'($urandom % 80);
      mode = (kind == 3) ? 2'd1 : 2'd0;
      tgt  = (kind == 3) ? 2'd0 : 2'(kind);
      src  = (kind == 3) ? 16'(16'h0100 + it * 32) : 16'($urandom);
      dst  = 16'(16'h4000 + it * 64);
      for (int i = 0; i < len; i++) begin
        if (kind == 3) begin
          vlo[int'(16'(src + i))] = 8'($urandom);
          vhi[int'(16'(src + i))] = 8'($urandom);
          exp[i] = rdVid(16'(src + i));
        end else exp[i] = busWord(16'(src + i));
      end
      logQ.delete();
      trigger(mode, tgt, src, dst, 16'(len), 8'(inc));
      waitFinish();
      okMem = 1;
      for (int i = 0; i < len; i++) begin
        a = 16'(dst + i * inc);
        if (rdMem(tgt, a) !== exp[i]) okMem = 0;
      end
      chk(okMem == 1, (kind == 3) ? "R5 copy contents" : "R2 bus contents", okMem, 1);
      chk(logQ.size() == len * (tgt == 2'd0 ? 2 : 1), "R9 push count", logQ.size(), len * (tgt == 2'd0 ? 2 : 1));
      okOrd = 1;
      if (tgt == 2'd0) begin
        for (int i = 0; i < len && 2*i+1 < logQ.size(); i++)
          if (logQ[2*i].kind != 2'd1 || logQ[2*i+1].kind != 2'd2 || logQ[2*i].addr != logQ[2*i+1].addr) okOrd = 0;
      end else begin
        foreach (logQ[i]) if (logQ[i].kind != 2'd0 || logQ[i].tgt != tgt) okOrd = 0;
      end
      chk(okOrd == 1, "R3 entry kind and order", okOrd, 1);
      chk(done && !busy, "R9 done after transfer", {done, busy}, 2'b10);
    end
    chk(pushFull == 0, "R4 push while full", pushFull, 0);

    // R10: accepted trigger clears done; zero length finishes with no push
    logQ.delete();
    trigger(2'd0, 2'd1, 16'h0, 16'h0300, 16'd0, 8'd1);
    chk(!done || !busy, "R10 done cleared", done, 0);
    repeat (5) @(negedge clk);
    chk(done && !busy && logQ.size() == 0, "R9 zero length", logQ.size(), 0);

    // fill with a trigger while armed (must be ignored)
    begin
      logic [15:0] v0;
      int okF;
      v0 = 16'hA55A;
      drainPct = 25;
      logQ.delete();
      trigger(2'd2, 2'd0, 16'h0, 16'h6000, 16'd5, 8'd2);
      trigger(2'd0, 2'd1, 16'h0, 16'h7000, 16'd2, 8'd1);
      chk(busy && dataReady, "R10 trigger while armed ignored", {busy, dataReady}, 2'b11);
      cpuWrite(v0);
      waitFinish();
      okF = 1;
      for (int k = 0; k <= 5; k++) if (rdVid(16'(16'h6000 + 2 * k)) !== v0) okF = 0;
      chk(okF == 1, "R7 fill contents", okF, 1);
      chk(logQ.size() == 12, "R7 fill push count", logQ.size(), 12);
      chk(logQ.size() > 2 && logQ[2].qsz == 0, "R6 fill waits for commit", logQ.size() > 2 ? logQ[2].qsz : -1, 0);
      chk(!scr.exists(int'(16'h7000)), "R10 ignored trigger wrote nothing", 1, 0);
    end

    // mid-fill data-port write
    begin
      logic [15:0] v0, v1;
      int j, okS, nw;
      v0 = 16'h1234; v1 = 16'hBEEF;
      drainPct = 40;
      logQ.delete();
      trigger(2'd2, 2'd0, 16'h0, 16'h8000, 16'd8, 8'd3);
      cpuWrite(v0);
      while (logQ.size() < 6) @(negedge clk);
      cpuWrite(v1);
      waitFinish();
      nw = logQ.size() / 2;
      chk(logQ.size() == 20, "R8 word count with extra write", logQ.size(), 20);
      j = -1;
      for (int k = 0; k < nw; k++) if (j < 0 && logWord(k) == v1) j = k;
      okS = (j >= 2) ? 1 : 0;
      for (int k = 0; k < nw; k++) begin
        if (logWord(k) !== ((k < j) ? v0 : v1)) okS = 0;
        if (logQ[2*k].addr !== 16'(16'h8000 + 3 * k)) okS = 0;
        if (rdVid(16'(16'h8000 + 3 * k)) !== ((k < j) ? v0 : v1)) okS = 0;
      end
      chk(okS == 1, "R8 value switch mid-fill", j, 2);
      chk(done && !busy, "R9 done after fill", {done, busy}, 2'b10);
    end
    chk(pushFull == 0, "R4 push while full (fill)", pushFull, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule